// File: doc/BRIEF.md
# Transmit Stall Watchdog

This block watches a transmit path for a hang and selects a recovery. On each accepted check tick it compares the live transmit counters against the values it saved at the previous check. These are the transmitted-frame count, the received-pause count, the transmit start-of-packet count and an upstream received count. When frames went out, or pause frames arrived that would explain idleness, the path is healthy. When the transmitter launched no packets while upstream kept delivering, the path is stalled.

A stall is handled in one of two ways. Normally the block briefly drops the transmit enable and then restores it. If the stall keeps recurring on consecutive checks past a limit, the block requests a full MAC reset instead. The reset sequence itself belongs to the logic that receives the request. A 2-bit status reports the outcome of the most recent check.

Top module: `tx_stall_watchdog`

## Requirements
- R1: After reset the status reads 0 (healthy), no reset request is raised, the toggle flag is low, and `tx_en_o` equals `tx_en_i` whenever no toggle is in progress.
- R2: If the frame count or the pause count differs from the value saved at the previous accepted check, the status is 0 and the consecutive-stall counter is cleared.
- R3: If neither of those changed and the start-of-packet count is nonzero, the status is 0.
- R4: If neither changed and the start-of-packet count is zero, a stall is declared only when the upstream count differs from its saved value and the start-of-packet count was also sampled as zero at the previous accepted check.
- R5: A stall found while the consecutive-stall counter is at most ESC_LIMIT (default 4) gives status 1 and increments the counter. It also drives `tx_en_o` low for exactly LOW_CYCLES (default 2) cycles, starting the cycle after the tick, and then restores `tx_en_i`.
- R6: A stall found while the counter exceeds ESC_LIMIT gives status 2, raises `reset_req_o` for exactly one cycle, clears the counter and leaves `tx_en_o` untouched.
- R7: When the start-of-packet count is zero but no stall is declared, the status is 0 and the counter is cleared.
- R8: Every accepted check saves the frame and pause counts. The upstream count is saved only on checks that sample it. The start-of-packet snapshot records "zero" only when the check sampled a zero count; otherwise it records "progressing".
- R9: Status is registered and changes in the cycle after an accepted tick. A tick that arrives while a toggle is in progress is ignored and changes neither the status nor any snapshot.
- R10: After reset the start-of-packet snapshot reads as "progressing", so the first check cannot declare a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| check_tick | input | 1 | Request for one progress check |
| tx_en_i | input | 1 | Transmit enable chosen by configuration |
| frame_cnt_i | input | FRAME_W | Transmitted-frame count |
| pause_cnt_i | input | PAUSE_W | Received-pause count |
| sop_cnt_i | input | SOP_W | Transmit start-of-packet count |
| up_cnt_i | input | UP_W | Upstream received count |
| tx_en_o | output | 1 | Transmit enable after toggle masking |
| toggle_o | output | 1 | High while the enable is being held low |
| reset_req_o | output | 1 | One-cycle full reset request |
| status_o | output | 2 | 0 healthy, 1 toggled, 2 reset requested |

## Verification
The bench uses the default parameters: 16-bit counters, ESC_LIMIT of 4 and LOW_CYCLES of 2. With an escalation limit this small, a table of about twenty checks can reach the escalation to a reset, the counter clearing that follows it, and its clearing by frame or pause activity. The two-cycle low window lets a tick land inside an active toggle, which shows that such a tick is dropped.

// File: rtl/stwd_pkg.sv
package stwd_pkg;
   typedef enum logic [1:0] {
      STWD_OK     = 2'd0,
      STWD_TOGGLE = 2'd1,
      STWD_RESET  = 2'd2
   } stwd_status_e;
endpackage

// File: rtl/stwd_snap.sv
// Saved copy of one progress counter with change detection.
module stwd_snap #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic         changed
);
   generate
      if (W < 1) begin : g_bad_w
         $error("stwd_snap: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] snap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    snap_q <= '0;
      else if (load) snap_q <= din;
   end

   assign changed = (din != snap_q);

   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(snap_q)); // R8
endmodule

// File: rtl/stwd_escalate.sv
// Consecutive-stall counter; over_o reports that the limit was passed.
module stwd_escalate #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic over_o
);
   generate
      if (LIMIT < 0) begin : g_bad_limit
         $error("stwd_escalate: LIMIT must not be negative");
      end
   endgenerate

   localparam int CW = $clog2(LIMIT + 2) + 1;
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign over_o = (cnt_q > LIM);

   AST_ESC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr && inc)); // R6
   AST_ESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM + 1'b1); // R5
endmodule

// File: rtl/stwd_toggle.sv
// Holds the transmit enable low for LOW_CYCLES cycles after start.
module stwd_toggle #(
   parameter int LOW_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (LOW_CYCLES < 1) begin : g_bad_len
         $error("stwd_toggle: LOW_CYCLES must be at least 1");
      end
   endgenerate

   generate
      if (LOW_CYCLES == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= start;
         end
         assign busy = busy_q;
      end else begin : g_count
         localparam int CW = $clog2(LOW_CYCLES + 1);
         localparam logic [CW-1:0] LOAD = CW'(LOW_CYCLES);
         logic [CW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (!rst_n)           left_q <= '0;
            else if (start)       left_q <= LOAD;
            else if (left_q != 0) left_q <= left_q - 1'b1;
         end
         assign busy = (left_q != '0);
      end
   endgenerate

   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R9
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy); // R5
endmodule

// File: rtl/tx_stall_watchdog.sv
module tx_stall_watchdog
   import stwd_pkg::*;
#(
   parameter int FRAME_W    = 16,
   parameter int PAUSE_W    = 16,
   parameter int SOP_W      = 16,
   parameter int UP_W       = 16,
   parameter int ESC_LIMIT  = 4,
   parameter int LOW_CYCLES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               check_tick,
   input  logic               tx_en_i,
   input  logic [FRAME_W-1:0] frame_cnt_i,
   input  logic [PAUSE_W-1:0] pause_cnt_i,
   input  logic [SOP_W-1:0]   sop_cnt_i,
   input  logic [UP_W-1:0]    up_cnt_i,
   output logic               tx_en_o,
   output logic               toggle_o,
   output logic               reset_req_o,
   output logic [1:0]         status_o
);
   localparam int RUN_W = $clog2(LOW_CYCLES + 1) + 1;

   logic busy, accept;
   logic frame_chg, pause_chg, up_chg;
   logic quiet, sampled, stall, over;
   logic esc_clr, esc_inc, tog_start;
   logic prev_sop_zero_q, reset_req_q;
   stwd_status_e status_q, status_d;

   assign accept = check_tick && !busy;

   stwd_snap #(.W(FRAME_W)) u_snap_frame (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .din(frame_cnt_i), .changed(frame_chg));

   stwd_snap #(.W(PAUSE_W)) u_snap_pause (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .din(pause_cnt_i), .changed(pause_chg));

   stwd_snap #(.W(UP_W)) u_snap_up (
      .clk(clk), .rst_n(rst_n), .load(accept && sampled),
      .din(up_cnt_i), .changed(up_chg));

   // Only the zero/nonzero nature of the previous start-of-packet sample
   // matters; reset value 0 means "progressing".
   always_ff @(posedge clk) begin
      if (!rst_n)      prev_sop_zero_q <= 1'b0;
      else if (accept) prev_sop_zero_q <= sampled;
   end

   always_comb begin
      quiet   = !frame_chg && !pause_chg;
      sampled = quiet && (sop_cnt_i == '0);
      stall   = sampled && up_chg && prev_sop_zero_q;
      if (stall) status_d = over ? STWD_RESET : STWD_TOGGLE;
      else       status_d = STWD_OK;
   end

   assign esc_clr   = accept && (!quiet || (sampled && !stall) || (stall && over));
   assign esc_inc   = accept && stall && !over;
   assign tog_start = esc_inc;

   stwd_escalate #(.LIMIT(ESC_LIMIT)) u_esc (
      .clk(clk), .rst_n(rst_n), .clr(esc_clr), .inc(esc_inc), .over_o(over));

   stwd_toggle #(.LOW_CYCLES(LOW_CYCLES)) u_tog (
      .clk(clk), .rst_n(rst_n), .start(tog_start), .busy(busy));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q    <= STWD_OK;
         reset_req_q <= 1'b0;
      end else begin
         reset_req_q <= accept && stall && over;
         if (accept) status_q <= status_d;
      end
   end

   assign status_o    = status_q;
   assign reset_req_o = reset_req_q;
   assign toggle_o    = busy;
   assign tx_en_o     = tx_en_i && !busy;

   // Checker state: length of the current low window.
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 1'b1;
      else           run_q <= '0;
   end

   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      status_o != 2'd3); // R6
   AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req_o |=> !reset_req_o); // R6
   AST_RESET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req_o |-> (status_o == 2'd2) && !toggle_o); // R6
   AST_TOGGLE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(toggle_o) |-> status_o == 2'd1); // R5
   AST_TOGGLE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(toggle_o) |-> run_q == RUN_W'(LOW_CYCLES)); // R5
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      toggle_o |=> $stable(status_o)); // R9
endmodule

// File: tb/tx_stall_watchdog_bench.sv
`timescale 1ns/1ps
module tx_stall_watchdog_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        check_tick = 1'b0;
   logic        tx_en_i = 1'b1;
   logic [15:0] frame_cnt_i = '0, pause_cnt_i = '0, sop_cnt_i = '0, up_cnt_i = '0;
   logic        tx_en_o, toggle_o, reset_req_o;
   logic [1:0]  status_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   tx_stall_watchdog u_tx_stall_watchdog (
      .clk(clk), .rst_n(rst_n), .check_tick(check_tick), .tx_en_i(tx_en_i),
      .frame_cnt_i(frame_cnt_i), .pause_cnt_i(pause_cnt_i),
      .sop_cnt_i(sop_cnt_i), .up_cnt_i(up_cnt_i),
      .tx_en_o(tx_en_o), .toggle_o(toggle_o),
      .reset_req_o(reset_req_o), .status_o(status_o));

   // {frame, pause, sop, upstream, expected status}
   localparam int NV = 21;
   localparam logic [65:0] VEC [NV] = '{
      {16'd0, 16'd0, 16'd0, 16'd0,  2'd0},
      {16'd0, 16'd0, 16'd0, 16'd5,  2'd1},
      {16'd0, 16'd0, 16'd0, 16'd9,  2'd1},
      {16'd3, 16'd0, 16'd0, 16'd9,  2'd0},
      {16'd3, 16'd0, 16'd0, 16'd12, 2'd0},
      {16'd3, 16'd0, 16'd0, 16'd13, 2'd1},
      {16'd3, 16'd0, 16'd0, 16'd14, 2'd1},
      {16'd3, 16'd0, 16'd0, 16'd15, 2'd1},
      {16'd3, 16'd0, 16'd7, 16'd15, 2'd0},
      {16'd3, 16'd0, 16'd0, 16'd16, 2'd0},
      {16'd3, 16'd1, 16'd0, 16'd20, 2'd0},
      {16'd3, 16'd1, 16'd0, 16'd20, 2'd0},
      {16'd3, 16'd1, 16'd0, 16'd21, 2'd1},
      {16'd3, 16'd1, 16'd0, 16'd22, 2'd1},
      {16'd3, 16'd1, 16'd0, 16'd23, 2'd1},
      {16'd3, 16'd1, 16'd0, 16'd24, 2'd1},
      {16'd3, 16'd1, 16'd0, 16'd25, 2'd1},
      {16'd3, 16'd1, 16'd0, 16'd26, 2'd2},
      {16'd3, 16'd1, 16'd0, 16'd27, 2'd1},
      {16'd3, 16'd1, 16'd0, 16'd27, 2'd0},
      {16'd3, 16'd1, 16'd0, 16'd28, 2'd1}
   };

   function automatic string tag_of(int i, int st);
      if (i == 3 || i == 10) return "R2";
      if (i == 8)            return "R3";
      if (i == 4 || i == 11) return "R10";
      if (i == 19)           return "R8";
      if (i == 0 || i == 9)  return "R7";
      if (st == 1)           return "R5";
      if (st == 2)           return "R6";
      return "R4";
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic drive(logic [15:0] f, logic [15:0] p, logic [15:0] s, logic [15:0] u);
      @(negedge clk);
      frame_cnt_i = f; pause_cnt_i = p; sop_cnt_i = s; up_cnt_i = u;
      check_tick = 1'b1;
      @(negedge clk);
      check_tick = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      frame_cnt_i = '0; pause_cnt_i = '0; sop_cnt_i = '0; up_cnt_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      check("R1", "status after reset", status_o, 0);
      check("R1", "reset_req after reset", reset_req_o, 0);
      check("R1", "toggle after reset", toggle_o, 0);
      check("R1", "tx_en after reset", tx_en_o, 1);

      for (int i = 0; i < NV; i++) begin
         int st;
         string t;
         st = int'(VEC[i][1:0]);
         t = tag_of(i, st);
         drive(VEC[i][65:50], VEC[i][49:34], VEC[i][33:18], VEC[i][17:2]);
         check(t, $sformatf("status vec %0d", i), status_o, st);
         if (st == 1) begin
            check("R5", "tx_en low cycle 1", tx_en_o, 0);
            check("R5", "reset_req quiet", reset_req_o, 0);
            @(negedge clk);
            check("R5", "tx_en low cycle 2", tx_en_o, 0);
            @(negedge clk);
            check("R5", "tx_en restored", tx_en_o, 1);
         end else if (st == 2) begin
            check("R6", "reset_req raised", reset_req_o, 1);
            check("R6", "tx_en kept", tx_en_o, 1);
            @(negedge clk);
            check("R6", "reset_req one cycle", reset_req_o, 0);
            @(negedge clk);
         end else begin
            check(t, "no reset_req", reset_req_o, 0);
            check(t, "tx_en kept", tx_en_o, 1);
            repeat (2) @(negedge clk);
         end
      end

      // Tick during an active toggle is ignored (R9)
      @(negedge clk);
      up_cnt_i = 16'd29; check_tick = 1'b1;
      @(negedge clk);
      check("R9", "status one cycle after tick", status_o, 1);
      frame_cnt_i = 16'd50;
      @(negedge clk);
      check_tick = 1'b0;
      check("R9", "status kept over busy tick", status_o, 1);
      repeat (2) @(negedge clk);
      drive(16'd3, 16'd1, 16'd0, 16'd30);
      check("R9", "busy tick left frame snapshot", status_o, 1);
      repeat (3) @(negedge clk);

      // Enable input passes through when idle (R1)
      tx_en_i = 1'b0;
      @(negedge clk);
      check("R1", "tx_en follows input low", tx_en_o, 0);
      tx_en_i = 1'b1;

      // Reset mid-run, then first check cannot stall (R10, R4)
      do_reset();
      @(negedge clk);
      check("R1", "status after second reset", status_o, 0);
      drive(16'd0, 16'd0, 16'd0, 16'd7);
      check("R10", "first check no stall", status_o, 0);
      repeat (2) @(negedge clk);
      drive(16'd0, 16'd0, 16'd0, 16'd8);
      check("R4", "stall after zero sample", status_o, 1);
      repeat (3) @(negedge clk);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule